// File: doc/BRIEF.md
# Indirect branch landing-pad checker

This block guards forward-edge control flow on a single-issue core. It watches instructions as they retire. When an indirect jump or indirect call retires while the check is on for the current privilege mode, the block expects the next retired instruction to be a landing-pad marker. That marker is an AUIPC with destination x0, and its 20-bit immediate carries a label. The label must equal bits [31:12] of register x7. A label of zero matches any x7 value. If the marker is missing or the label differs, the block raises a one-cycle violation pulse with a fixed cause code, which the trap logic turns into a software-check exception.

The enable for user mode comes from a bit of the supervisor environment-config register. The enable for supervisor mode comes from a bit of the machine environment-config register. Machine mode is never checked. The expectation lasts for exactly one retired instruction. Trap entry cancels it.

Top module: `lpad_guard`

## Requirements
- R1: After reset, the violation output is 0, the cause output is 0, and no landing pad is expected. A non-pad instruction retired first produces no violation.
- R2: Suppose an indirect transfer retires in an enabled mode, and the next retired instruction is not a landing pad. Then `viol_valid` is 1 for one clock, in the cycle after that instruction retires, and `viol_cause` equals `CAUSE_VAL` (default 2).
- R3: A landing pad has opcode bits [6:0] = 0010111 and rd bits [11:7] = 0. When a landing pad retires as the expected instruction and its label bits [31:12] equal `x7_hi`, no violation is raised.
- R4: When the expected instruction is a landing pad whose label is nonzero and differs from `x7_hi`, a violation is raised.
- R5: A landing pad with label 0 satisfies the expectation for any `x7_hi` value.
- R6: An AUIPC with rd not equal to 0 is not a landing pad. As the expected instruction, it raises a violation.
- R7: Privilege encoding is U = 00, S = 01, M = 11, and 10 is treated as disabled. An indirect transfer arms the expectation in U only when `en_user` = 1, and in S only when `en_super` = 1. When the mode's enable is 0, no expectation is armed.
- R8: An indirect transfer retired in M mode never arms an expectation, whatever the enable inputs are.
- R9: A `trap_entry` pulse clears any pending expectation. If it comes in the same cycle as a retire, that retire is still checked but arms nothing.
- R10: Only the next retired instruction is checked. Cycles with `ret_valid` = 0 neither clear nor consume the expectation, and an instruction retired after the checked one is not checked.
- R11: When `viol_valid` is 0, `viol_cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_insn | input | 32 | Word of the retiring instruction |
| ret_is_ind | input | 1 | The retiring instruction is an indirect jump or call |
| x7_hi | input | LBL_W | Bits [31:12] of register x7 |
| priv | input | 2 | Current privilege mode (U = 00, S = 01, M = 11) |
| en_user | input | 1 | User-mode enable, from the supervisor environment config |
| en_super | input | 1 | Supervisor-mode enable, from the machine environment config |
| trap_entry | input | 1 | Trap entry this cycle |
| viol_valid | output | 1 | Forward-edge violation pulse |
| viol_cause | output | CAUSE_W | Cause code while the pulse is high, otherwise 0 |

## Verification
The bench uses the default parameters: a 20-bit label, a 4-bit cause field and cause value 2. With these, a label compare over the full field width and cause values in their real encoding can be reached. Random sequences often place indirect transfers back to back, mix retire gaps with trap pulses, and change mode and enables between arming and checking. Directed cases cover a zero label, an AUIPC whose rd is nonzero, a label that differs in a single bit, and a trap in the same cycle as a retire.

// File: rtl/lpad_pkg.sv
// Package: shared encodings for the landing-pad checker.
// Assumes 32-bit instruction words and the standard two-bit privilege code.
package lpad_pkg;
    localparam int ILEN = 32;
    localparam logic [6:0] OPC_AUIPC = 7'b0010111;

    typedef enum logic [1:0] {
        PRIV_U   = 2'b00,
        PRIV_S   = 2'b01,
        PRIV_RSV = 2'b10,
        PRIV_M   = 2'b11
    } priv_e;
endpackage

// File: rtl/lpad_decode.sv
// Module: recognises a landing-pad marker and compares its label.
// Assumes the label sits in instruction bits [ILEN-1:ILEN-LBL_W].
module lpad_decode
    import lpad_pkg::*;
#(
    parameter int LBL_W = 20
) (
    input  logic [ILEN-1:0]  insn,
    input  logic [LBL_W-1:0] x7_hi,
    output logic             pad_ok
);
    localparam int LBL_LSB = ILEN - LBL_W;

    logic             is_pad;
    logic [LBL_W-1:0] label;

    // Split the word into opcode, rd and label, and decide whether the pad is accepted.
    always_comb begin
        label  = insn[ILEN-1:LBL_LSB];
        is_pad = (insn[6:0] == OPC_AUIPC) && (insn[11:7] == 5'd0);
        pad_ok = is_pad && ((label == '0) || (label == x7_hi));
    end
endmodule

// File: rtl/lpad_mode_gate.sv
// Module: selects the check enable that belongs to the current privilege.
// Assumes M mode and the reserved code are never checked.
module lpad_mode_gate
    import lpad_pkg::*;
(
    input  logic [1:0] priv,
    input  logic       en_user,
    input  logic       en_super,
    output logic       mode_en
);
    // Map the privilege code onto its enable bit.
    always_comb begin
        unique case (priv_e'(priv))
            PRIV_U:  mode_en = en_user;
            PRIV_S:  mode_en = en_super;
            default: mode_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/lpad_track.sv
// Module: holds the expected-landing-pad flag and registers the violation.
// Assumes a retire and a trap may fall in the same cycle, and the trap wins for arming.
module lpad_track #(
    parameter int             CAUSE_W   = 4,
    parameter logic [CAUSE_W-1:0] CAUSE_VAL = 4'd2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ret_valid,
    input  logic               ret_is_ind,
    input  logic               mode_en,
    input  logic               pad_ok,
    input  logic               trap_entry,
    output logic               viol_valid,
    output logic [CAUSE_W-1:0] viol_cause
);
    logic expect_q;
    logic fault;

    // A fault is a retire, while a pad is expected, that is not an accepted pad.
    always_comb fault = ret_valid && expect_q && !pad_ok;

    // Update the one-deep expectation on each retire and cancel it on trap entry.
    always_ff @(posedge clk) begin
        if (!rst_n)          expect_q <= 1'b0;
        else if (trap_entry) expect_q <= 1'b0;
        else if (ret_valid)  expect_q <= ret_is_ind && mode_en;
    end

    // Register the violation pulse and its cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_valid <= 1'b0;
            viol_cause <= '0;
        end else begin
            viol_valid <= fault;
            viol_cause <= fault ? CAUSE_VAL : '0;
        end
    end
endmodule

// File: rtl/lpad_guard.sv
// Module: top level of the forward-edge landing-pad checker.
// Assumes one retire per cycle at most, with x7_hi valid in the same cycle.
module lpad_guard
    import lpad_pkg::*;
#(
    parameter int             LBL_W     = 20,
    parameter int             CAUSE_W   = 4,
    parameter logic [CAUSE_W-1:0] CAUSE_VAL = 4'd2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ret_valid,
    input  logic [31:0]        ret_insn,
    input  logic               ret_is_ind,
    input  logic [LBL_W-1:0]   x7_hi,
    input  logic [1:0]         priv,
    input  logic               en_user,
    input  logic               en_super,
    input  logic               trap_entry,
    output logic               viol_valid,
    output logic [CAUSE_W-1:0] viol_cause
);
    logic pad_ok;
    logic mode_en;

    lpad_decode #(.LBL_W(LBL_W)) u_dec (
        .insn   (ret_insn),
        .x7_hi  (x7_hi),
        .pad_ok (pad_ok)
    );

    lpad_mode_gate u_gate (
        .priv     (priv),
        .en_user  (en_user),
        .en_super (en_super),
        .mode_en  (mode_en)
    );

    lpad_track #(.CAUSE_W(CAUSE_W), .CAUSE_VAL(CAUSE_VAL)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .ret_valid  (ret_valid),
        .ret_is_ind (ret_is_ind),
        .mode_en    (mode_en),
        .pad_ok     (pad_ok),
        .trap_entry (trap_entry),
        .viol_valid (viol_valid),
        .viol_cause (viol_cause)
    );
endmodule

// File: rtl/lpad_guard_chk.sv
// Module: assertion checker for lpad_guard, attached with bind.
// Assumes the privilege encoding of lpad_pkg.
module lpad_guard_chk #(
    parameter int             LBL_W     = 20,
    parameter int             CAUSE_W   = 4,
    parameter logic [CAUSE_W-1:0] CAUSE_VAL = 4'd2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ret_valid,
    input logic [31:0]        ret_insn,
    input logic               ret_is_ind,
    input logic [LBL_W-1:0]   x7_hi,
    input logic [1:0]         priv,
    input logic               en_user,
    input logic               en_super,
    input logic               trap_entry,
    input logic               viol_valid,
    input logic [CAUSE_W-1:0] viol_cause
);
    logic armed_ref;
    logic is_pad;
    logic arm_now;

    // Compute an independent view of whether this retire could arm a check, and of the pad shape.
    always_comb begin
        is_pad  = (ret_insn[6:0] == 7'b0010111) && (ret_insn[11:7] == 5'd0);
        arm_now = ret_is_ind && ((priv == 2'b00 && en_user) || (priv == 2'b01 && en_super));
    end

    // Track whether a landing pad is owed.
    always_ff @(posedge clk) begin
        if (!rst_n)          armed_ref <= 1'b0;
        else if (trap_entry) armed_ref <= 1'b0;
        else if (ret_valid)  armed_ref <= arm_now;
    end

    // R2
    cause_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> viol_cause == CAUSE_VAL);
    // R11
    cause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !viol_valid |-> viol_cause == '0);
    // R3
    match_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && is_pad && ret_insn[31:32-LBL_W] == x7_hi) |=> !viol_valid);
    // R5
    zero_label_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && is_pad && ret_insn[31:32-LBL_W] == '0) |=> !viol_valid);
    // R10
    no_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_valid |=> !viol_valid);
    // R8
    unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !armed_ref) |=> !viol_valid);
    // R6
    rd_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && armed_ref && ret_insn[6:0] == 7'b0010111 && ret_insn[11:7] != 5'd0)
        |=> viol_valid);
endmodule

bind lpad_guard lpad_guard_chk #(
    .LBL_W(LBL_W), .CAUSE_W(CAUSE_W), .CAUSE_VAL(CAUSE_VAL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_insn(ret_insn),
    .ret_is_ind(ret_is_ind), .x7_hi(x7_hi), .priv(priv), .en_user(en_user),
    .en_super(en_super), .trap_entry(trap_entry), .viol_valid(viol_valid),
    .viol_cause(viol_cause)
);

// File: tb/sim_lpad_guard.sv
module sim_lpad_guard;
    localparam int LW = 20;
    localparam int CW = 4;
    localparam logic [CW-1:0] CV = 4'd2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ret_valid = 1'b0;
    logic [31:0]   ret_insn = '0;
    logic          ret_is_ind = 1'b0;
    logic [LW-1:0] x7_hi = '0;
    logic [1:0]    priv = 2'b00;
    logic          en_user = 1'b0;
    logic          en_super = 1'b0;
    logic          trap_entry = 1'b0;
    logic          viol_valid;
    logic [CW-1:0] viol_cause;

    int checks = 0;
    int fails  = 0;
    bit model_armed = 1'b0;

    always #5 clk = ~clk;

    lpad_guard u0 (.*);

    function automatic logic [31:0] pad(input logic [19:0] lbl, input logic [4:0] rd);
        return {lbl, rd, 7'b0010111};
    endfunction

    function automatic bit accepted(input logic [31:0] w, input logic [LW-1:0] x);
        return (w[6:0] == 7'b0010111) && (w[11:7] == 5'd0) && (w[31:12] == '0 || w[31:12] == x);
    endfunction

    function automatic bit enabled(input logic [1:0] p, input logic eu, input logic es);
        return (p == 2'b00 && eu) || (p == 2'b01 && es);
    endfunction

    task automatic check(input string tag, input logic av, input logic ev,
                         input logic [CW-1:0] ac, input logic [CW-1:0] ec);
        checks++;
        if (av !== ev || ac !== ec) begin
            fails++;
            $display("FAIL %s: viol=%0b cause=%0d expected viol=%0b cause=%0d", tag, av, ac, ev, ec);
        end
    endtask

    // Drive one cycle, predict, and check the output after the edge.
    task automatic step(input string tag, input logic v, input logic [31:0] w, input logic ind,
                        input logic [LW-1:0] x, input logic [1:0] p, input logic eu,
                        input logic es, input logic tr);
        bit ev;
        ret_valid = v; ret_insn = w; ret_is_ind = ind; x7_hi = x;
        priv = p; en_user = eu; en_super = es; trap_entry = tr;
        ev = v && model_armed && !accepted(w, x);
        if (tr)     model_armed = 1'b0;
        else if (v) model_armed = ind && enabled(p, eu, es);
        @(posedge clk); #1;
        check(tag, viol_valid, ev, viol_cause, ev ? CV : '0);
    endtask

    localparam logic [31:0] NOP = 32'h0000_0013;

    initial begin
        #200000000;
        fails++;
        $display("FAIL watchdog: viol=%0b cause=%0d expected viol=0 cause=0", viol_valid, viol_cause);
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
        $finish;
    end

    initial begin
        int unsigned seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1", viol_valid, 1'b0, viol_cause, '0);
        step("R1", 1, NOP, 0, 20'h0, 2'b00, 1, 1, 0);
        // R2 missing pad in U
        step("R2", 1, NOP, 1, 20'h12345, 2'b00, 1, 0, 0);
        step("R2", 1, NOP, 0, 20'h12345, 2'b00, 1, 0, 0);
        step("R11", 1, NOP, 0, 20'h12345, 2'b00, 1, 0, 0);
        // R3 matching label in S
        step("R3", 1, NOP, 1, 20'hABCDE, 2'b01, 0, 1, 0);
        step("R3", 1, pad(20'hABCDE, 0), 0, 20'hABCDE, 2'b01, 0, 1, 0);
        // R4 single-bit mismatch
        step("R4", 1, NOP, 1, 20'hABCDE, 2'b01, 0, 1, 0);
        step("R4", 1, pad(20'hABCDF, 0), 0, 20'hABCDE, 2'b01, 0, 1, 0);
        // R5 zero label
        step("R5", 1, NOP, 1, 20'hFFFFF, 2'b00, 1, 1, 0);
        step("R5", 1, pad(20'h0, 0), 0, 20'hFFFFF, 2'b00, 1, 1, 0);
        // R6 rd nonzero
        step("R6", 1, NOP, 1, 20'h00042, 2'b00, 1, 1, 0);
        step("R6", 1, pad(20'h00042, 5'd7), 0, 20'h00042, 2'b00, 1, 1, 0);
        // R7 disabled mode
        step("R7", 1, NOP, 1, 20'h1, 2'b00, 0, 1, 0);
        step("R7", 1, NOP, 0, 20'h1, 2'b00, 0, 1, 0);
        step("R7", 1, NOP, 1, 20'h1, 2'b01, 1, 0, 0);
        step("R7", 1, NOP, 0, 20'h1, 2'b01, 1, 0, 0);
        // R8 M mode
        step("R8", 1, NOP, 1, 20'h1, 2'b11, 1, 1, 0);
        step("R8", 1, NOP, 0, 20'h1, 2'b11, 1, 1, 0);
        // R9 trap clears
        step("R9", 1, NOP, 1, 20'h1, 2'b00, 1, 1, 0);
        step("R9", 0, NOP, 0, 20'h1, 2'b00, 1, 1, 1);
        step("R9", 1, NOP, 0, 20'h1, 2'b00, 1, 1, 0);
        step("R9", 1, NOP, 1, 20'h1, 2'b00, 1, 1, 0);
        step("R9", 1, NOP, 1, 20'h1, 2'b00, 1, 1, 1);
        step("R9", 1, NOP, 0, 20'h1, 2'b00, 1, 1, 0);
        // R10 gaps keep expectation, only next retire checked
        step("R10", 1, NOP, 1, 20'h5, 2'b00, 1, 1, 0);
        step("R10", 0, NOP, 0, 20'h5, 2'b00, 1, 1, 0);
        step("R10", 0, NOP, 0, 20'h5, 2'b00, 1, 1, 0);
        step("R10", 1, NOP, 0, 20'h5, 2'b00, 1, 1, 0);
        step("R10", 1, NOP, 0, 20'h5, 2'b00, 1, 1, 0);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [19:0] lbl;
            logic [31:0] w;
            int k;
            logic [19:0] x;
            x = ($urandom % 4 == 0) ? 20'h0 : 20'($urandom % 8);
            lbl = ($urandom % 3 == 0) ? 20'h0 : 20'($urandom % 8);
            k = $urandom % 4;
            w = (k == 0) ? NOP : pad(lbl, (k == 1) ? 5'($urandom) : 5'd0);
            step("R2", ($urandom % 5) != 0, w, ($urandom % 3) == 0, x,
                 2'($urandom), 1'($urandom), 1'($urandom), ($urandom % 16) == 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule